// File: doc/BRIEF.md
# FIFO-fed I2S frame generator

This block turns a byte-wide FIFO of stereo 16-bit PCM into an I2S stream that never stops. It runs from an audio master clock of 256 times the sample rate; for 44.1 kHz this is 11.2896 MHz. The master clock is divided by four to give the bit clock, so each stereo frame is 64 bit-clock slots long. A slot counter, numbered 0 to 63 here, sets all the timing. Slots 0–31 carry the left channel and slots 32–63 carry the right.

During the right half of each frame the block fetches the next sample pair. It checks the FIFO's ready flag once, at the start of slot 44. If the flag is high, the block drives an active-low read strobe in slots 44, 46, 48 and 50. It stores the four bytes in a staging set: low then high byte of left, then low then high byte of right, which is the usual little-endian PCM layout.

At the frame boundary the staging set moves to the playback registers. If the flag was low, the block performs no read and loads zeros, so the next frame is silence and the FIFO keeps its contents. All outputs come from registers on the master clock. SD and LRCK change only on falling edges of SCK.

Top module: `i2s_fifo_player`

## Requirements
- R1: `i2s_sck` is the master clock divided by 4. It is low for two master-clock cycles and then high for two. One stereo frame holds 64 SCK periods.
- R2: `i2s_lrck` is low in slots 0–31 (left) and high in slots 32–63 (right). It changes only together with a falling edge of SCK.
- R3: If `fifo_ready` is high at the start of slot 44, `fifo_rd_n` is low for exactly one SCK period in each of slots 44, 46, 48 and 50. It is high in every other slot. A strobe only ever occurs while LRCK is high.
- R4: The first byte read becomes left bits 7:0 and the second becomes left bits 15:8. The third becomes right bits 7:0 and the fourth becomes right bits 15:8.
- R5: If `fifo_ready` is low at the start of slot 44, no strobe occurs in that frame. The following frame carries zero for both channels, and the FIFO keeps its bytes for a later frame.
- R6: SD carries each sample MSB first. Left bit 15 is in slot 1 and left bit 0 is in slot 16. Right bit 15 is in slot 33 and right bit 0 is in slot 48. Slots 0, 17–32 and 49–63 carry 0. SD changes only together with a falling edge of SCK.
- R7: A pair fetched during frame N is sent in frame N+1. The fetch never alters the frame being sent.
- R8: Reset is synchronous and active-high. After reset `fifo_rd_n`=1 and `i2s_sck`, `i2s_lrck` and `i2s_sd` are 0. The first SCK rise after reset opens slot 0, and the first frame is silence.
- R9: Ready is sampled once per frame, so the block reads all four bytes or none. A FIFO that holds only part of a frame, with ready low, yields silence and keeps its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock, 256 × sample rate |
| rst | input | 1 | Synchronous active-high reset |
| fifo_ready | input | 1 | FIFO holds at least one full stereo frame (4 bytes) |
| fifo_data | input | 8 | FIFO read data, valid while the strobe is low |
| fifo_rd_n | output | 1 | Active-low FIFO read strobe |
| i2s_sck | output | 1 | I2S bit clock |
| i2s_lrck | output | 1 | I2S word select, high for right |
| i2s_sd | output | 1 | I2S serial data |

## Verification
Each result has a fixed due time after its stimulus:
- **SD bits:** a sample pair offered before slot 44 of frame N appears on SD in frame N+1. Bit k of a channel is due in slot 16−k of its half.
- **Strobes:** the strobes for a pair are due in slots 44–50 of the same frame N.
- **Reset values:** these are due one master-clock edge after reset is sampled.

The bench counts SCK rising edges from reset to know the slot number. It samples SD, LRCK and the strobe in the middle of each SCK high phase. At slot 63 it compares the decoded frame, the padding and the strobe slot mask with the items the driver queued one frame earlier. It checks the SCK period by counting master clocks between rises.

// File: rtl/i2sgen_pkg.sv
package i2sgen_pkg;
  localparam int unsigned BYTE_W = 8;

  // What a given slot of the frame carries on the data line
  typedef enum logic [1:0] {
    ROLE_PAD   = 2'd0,
    ROLE_LEFT  = 2'd1,
    ROLE_RIGHT = 2'd2
  } slot_role_e;
endpackage

// File: rtl/i2sgen_clkgen.sv
// Bit-clock divider and frame slot counter.
module i2sgen_clkgen #(
  parameter  int unsigned DIV    = 4,
  parameter  int unsigned SLOTS  = 64,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned PH_W   = $clog2(DIV)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              adv_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output logic              sck_o
);
  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sck_q;

  // last master-clock cycle of a slot: SCK falls and the slot advances
  assign adv_o      = (ph_q == PH_W'(DIV - 1));
  assign slot_nxt_o = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
  assign slot_o     = slot_q;
  assign sck_o      = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      slot_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      ph_q <= adv_o ? '0 : ph_q + 1'b1;
      if (adv_o)
        slot_q <= slot_nxt_o;
      if (ph_q == PH_W'(DIV / 2 - 1))
        sck_q <= 1'b1;
      else if (adv_o)
        sck_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2sgen_fetch.sv
// Strobes the FIFO at fixed slots, stages the bytes, hands them over at the frame edge.
module i2sgen_fetch
  import i2sgen_pkg::*;
#(
  parameter  int unsigned SLOTS      = 64,
  parameter  int unsigned SAMPLE_W   = 16,
  parameter  int unsigned FIRST_SLOT = 44,
  parameter  int unsigned STRIDE     = 2,
  localparam int unsigned SLOT_W     = $clog2(SLOTS),
  localparam int unsigned BPS        = SAMPLE_W / BYTE_W,
  localparam int unsigned BYTES      = 2 * BPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [SLOT_W-1:0]   slot_nxt,
  input  logic                fifo_ready,
  input  logic [BYTE_W-1:0]   fifo_data,
  output logic                rd_n_o,
  output logic [SAMPLE_W-1:0] play_l_o,
  output logic [SAMPLE_W-1:0] play_r_o
);
  logic [BYTES-1:0]    hit_nxt;
  logic [BYTES-1:0]    hit_cur;
  logic [BYTE_W-1:0]   stage_q [BYTES];
  logic [SAMPLE_W-1:0] stage_l, stage_r;
  logic                take_q;
  logic                rd_n_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam int unsigned SLOT_B = FIRST_SLOT + b * STRIDE;
    assign hit_nxt[b] = (slot_nxt == SLOT_W'(SLOT_B));
    assign hit_cur[b] = (slot == SLOT_W'(SLOT_B));

    always_ff @(posedge clk) begin
      if (rst)
        stage_q[b] <= '0;
      else if (adv && hit_nxt[0] && !fifo_ready)
        stage_q[b] <= '0;
      else if (adv && hit_cur[b] && !rd_n_q)
        stage_q[b] <= fifo_data;
    end
  end

  // little-endian assembly: low byte first, left before right
  always_comb begin
    for (int i = 0; i < BPS; i++) begin
      stage_l[i*BYTE_W +: BYTE_W] = stage_q[i];
      stage_r[i*BYTE_W +: BYTE_W] = stage_q[BPS + i];
    end
  end

  // ready is taken once per frame; the remaining strobes follow that decision
  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      rd_n_q <= 1'b1;
    end else if (adv) begin
      if (hit_nxt[0]) begin
        take_q <= fifo_ready;
        rd_n_q <= !fifo_ready;
      end else begin
        rd_n_q <= !(take_q && (|hit_nxt[BYTES-1:1]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      play_l_o <= '0;
      play_r_o <= '0;
    end else if (adv && slot_nxt == '0) begin
      play_l_o <= stage_l;
      play_r_o <= stage_r;
    end
  end

  assign rd_n_o = rd_n_q;
endmodule

// File: rtl/i2sgen_serial.sv
// Selects the data bit for each slot and registers LRCK and SD.
module i2sgen_serial
  import i2sgen_pkg::*;
#(
  parameter  int unsigned SLOTS    = 64,
  parameter  int unsigned SAMPLE_W = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned POS_W    = SLOT_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [SLOT_W-1:0]   slot_nxt,
  input  logic [SAMPLE_W-1:0] play_l,
  input  logic [SAMPLE_W-1:0] play_r,
  output logic                lrck_o,
  output logic                sd_o
);
  logic [POS_W-1:0]    pos;
  logic                right_half;
  logic [SAMPLE_W-1:0] word;
  logic                bit_d;
  slot_role_e          role;

  assign pos        = slot_nxt[POS_W-1:0];
  assign right_half = slot_nxt[SLOT_W-1];
  assign word       = right_half ? play_r : play_l;

  always_comb begin
    bit_d = 1'b0;
    role  = ROLE_PAD;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (pos == POS_W'(i + 1)) begin
        bit_d = word[SAMPLE_W-1-i];
        role  = right_half ? ROLE_RIGHT : ROLE_LEFT;
      end
    end
    if (role == ROLE_PAD)
      bit_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_o <= 1'b0;
      sd_o   <= 1'b0;
    end else if (adv) begin
      lrck_o <= right_half;
      sd_o   <= bit_d;
    end
  end
endmodule

// File: rtl/i2s_fifo_player.sv
module i2s_fifo_player #(
  parameter  int unsigned MCLK_PER_SCK  = 4,
  parameter  int unsigned FRAME_SLOTS   = 64,
  parameter  int unsigned SAMPLE_W      = 16,
  parameter  int unsigned RD_FIRST_SLOT = 44,
  parameter  int unsigned RD_STRIDE     = 2,
  localparam int unsigned SLOT_W        = $clog2(FRAME_SLOTS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_ready,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd_n,
  output logic       i2s_sck,
  output logic       i2s_lrck,
  output logic       i2s_sd
);
  logic                adv;
  logic [SLOT_W-1:0]   slot, slot_nxt;
  logic [SAMPLE_W-1:0] play_l, play_r;

  i2sgen_clkgen #(
    .DIV   (MCLK_PER_SCK),
    .SLOTS (FRAME_SLOTS)
  ) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .adv_o      (adv),
    .slot_o     (slot),
    .slot_nxt_o (slot_nxt),
    .sck_o      (i2s_sck)
  );

  i2sgen_fetch #(
    .SLOTS      (FRAME_SLOTS),
    .SAMPLE_W   (SAMPLE_W),
    .FIRST_SLOT (RD_FIRST_SLOT),
    .STRIDE     (RD_STRIDE)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .slot       (slot),
    .slot_nxt   (slot_nxt),
    .fifo_ready (fifo_ready),
    .fifo_data  (fifo_data),
    .rd_n_o     (fifo_rd_n),
    .play_l_o   (play_l),
    .play_r_o   (play_r)
  );

  i2sgen_serial #(
    .SLOTS    (FRAME_SLOTS),
    .SAMPLE_W (SAMPLE_W)
  ) u_serial (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .slot_nxt (slot_nxt),
    .play_l   (play_l),
    .play_r   (play_r),
    .lrck_o   (i2s_lrck),
    .sd_o     (i2s_sd)
  );
endmodule

// File: rtl/i2s_fifo_player_chk.sv
module i2s_fifo_player_chk #(
  parameter int unsigned DIV   = 4,
  parameter int unsigned SLOTS = 64
) (
  input logic clk,
  input logic rst,
  input logic rd_n,
  input logic sck,
  input logic lrck,
  input logic sd
);
  logic        sck_d;
  logic        seen_rise;
  logic [15:0] mclk_cnt;
  logic [15:0] rise_cnt;
  logic        rise;

  assign rise = sck && !sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      seen_rise <= 1'b0;
      mclk_cnt  <= '0;
      rise_cnt  <= '0;
    end else begin
      sck_d    <= sck;
      mclk_cnt <= rise ? 16'd1 : mclk_cnt + 16'd1;
      if (rise)
        seen_rise <= 1'b1;
      if (!lrck && sck_d && $past(lrck))
        rise_cnt <= '0;
      else if (rise && lrck)
        rise_cnt <= rise_cnt + 16'd1;
    end
  end

  // R1: SCK rises every DIV master clocks
  assert_sck_period_R1: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_rise) |-> (mclk_cnt == 16'(DIV)));

  // R2: right half spans half the frame's bit clocks
  assert_right_half_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(lrck) |-> (rise_cnt == 16'(SLOTS / 2)));

  assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck) |-> $fell(sck));

  assert_strobe_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_n) |-> $fell(sck));

  assert_strobe_in_right_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> lrck);

  assert_sd_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd) |-> $fell(sck));

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (rd_n && !sck && !lrck && !sd));
endmodule

bind i2s_fifo_player i2s_fifo_player_chk #(
  .DIV   (MCLK_PER_SCK),
  .SLOTS (FRAME_SLOTS)
) i_chk (
  .clk  (clk),
  .rst  (rst),
  .rd_n (fifo_rd_n),
  .sck  (i2s_sck),
  .lrck (i2s_lrck),
  .sd   (i2s_sd)
);

// File: tb/test_i2s_fifo_player.sv
module test_i2s_fifo_player;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NSTEPS     = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_ready = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_rd_n, i2s_sck, i2s_lrck, i2s_sd;

  typedef struct packed { logic [15:0] l; logic [15:0] r; } pair_t;

  int    n_checks = 0;
  int    n_fail   = 0;
  logic [7:0] fq [$];
  pair_t exp_q [$];
  bit    exp_rd [NSTEPS+2];
  bit    fifo_hold = 1'b0;
  int    frame_no = -1;
  int    frames_done = 0;

  i2s_fifo_player i_i2s_fifo_player (
    .clk(clk), .rst(rst), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .fifo_rd_n(fifo_rd_n), .i2s_sck(i2s_sck), .i2s_lrck(i2s_lrck), .i2s_sd(i2s_sd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // FIFO model: strobe-low presents the head byte, the rising strobe pops it
  logic prev_rd_n = 1'b1;
  always @(negedge clk) begin
    if (prev_rd_n == 1'b0 && fifo_rd_n == 1'b1 && fq.size() > 0)
      void'(fq.pop_front());
    prev_rd_n  = fifo_rd_n;
    fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
    fifo_ready = (fq.size() >= 4) && !fifo_hold;
  end

  // driver: at the start of frame k, offer bytes and queue what frame k+1 must carry
  task automatic frame_step(input int k, input int nbytes, input logic [31:0] word,
                            input bit hold);
    pair_t p;
    bit    rdy;
    wait (frame_no == k);
    for (int i = 0; i < nbytes; i++) fq.push_back(word[8*i +: 8]);
    fifo_hold = hold;
    rdy = (fq.size() >= 4) && !hold;
    p.l = rdy ? {fq[1], fq[0]} : 16'h0000;   // R4 byte order
    p.r = rdy ? {fq[3], fq[2]} : 16'h0000;
    exp_rd[k] = rdy;
    exp_q.push_back(p);
  endtask

  // monitor
  logic        sck_prev = 1'b0;
  int          rises = 0;
  int          mclk_since = 0;
  bit          per_ok = 1'b1;
  bit          lr_ok = 1'b1;
  logic [63:0] bits, rdmask;

  always @(negedge clk) begin
    if (!rst) begin
      mclk_since++;
      if (i2s_sck && !sck_prev) begin
        int slot;
        slot = rises % 64;
        if (rises > 0 && mclk_since != 4) per_ok = 1'b0;
        mclk_since = 0;
        rises++;
        if (slot == 0) frame_no++;
        bits[slot]   = i2s_sd;
        rdmask[slot] = !fifo_rd_n;
        if (i2s_lrck != (slot >= 32)) lr_ok = 1'b0;
        if (slot == 63) begin
          pair_t e;
          logic [15:0] gl, gr;
          logic [63:0] pad, emask;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
          for (int i = 0; i < 16; i++) begin
            gl[15-i] = bits[1+i];
            gr[15-i] = bits[33+i];
          end
          pad = bits & ~(64'h0001_FFFE_0001_FFFE);
          emask = exp_rd[frame_no] ? ((64'd1 << 44) | (64'd1 << 46) | (64'd1 << 48) | (64'd1 << 50)) : 64'd0;
          // R6 R7 R4 R5 R9: decoded pair equals what was offered one frame earlier
          check({gl, gr} == {e.l, e.r}, "R6/R7", $sformatf("frame %0d data", frame_no),
                {32'd0, gl, gr}, {32'd0, e.l, e.r});
          check(pad == 64'd0, "R6", "padding slots", pad, 64'd0);
          check(rdmask == emask, "R3/R5/R9", $sformatf("strobe slots frame %0d", frame_no),
                rdmask, emask);
          check(lr_ok, "R2", "lrck per slot", {63'd0, lr_ok}, 64'd1);
          check(per_ok, "R1", "sck period", {63'd0, per_ok}, 64'd1);
          lr_ok = 1'b1;
          per_ok = 1'b1;
          frames_done++;
        end
      end
      sck_prev = i2s_sck;
    end
  end

  initial begin
    exp_q.push_back('0);                  // R8: first frame after reset is silent
    repeat (5) @(negedge clk);
    check(fifo_rd_n == 1'b1, "R8", "reset rd_n", {63'd0, fifo_rd_n}, 64'd1);
    check(i2s_sck == 1'b0, "R8", "reset sck", {63'd0, i2s_sck}, 64'd0);
    check(i2s_lrck == 1'b0, "R8", "reset lrck", {63'd0, i2s_lrck}, 64'd0);
    check(i2s_sd == 1'b0, "R8", "reset sd", {63'd0, i2s_sd}, 64'd0);
    rst = 1'b0;
    frame_step(0,  4, {16'h7FFE, 16'h8001}, 1'b0);
    frame_step(1,  4, {16'h3C5A, 16'hA5C3}, 1'b0);
    frame_step(2,  4, {16'h0000, 16'hFFFF}, 1'b0);
    frame_step(3,  0, 32'h0, 1'b1);                    // R5 not ready
    frame_step(4,  2, {16'h0000, 16'h1234}, 1'b0);     // R9 partial frame
    frame_step(5,  2, {16'h0000, 16'h5678}, 1'b0);     // R9 completes it
    frame_step(6,  4, {16'hBEEF, 16'hDEAD}, 1'b1);     // R5 held, bytes retained
    frame_step(7,  0, 32'h0, 1'b0);
    frame_step(8,  4, {16'h8000, 16'h0001}, 1'b0);     // R4 byte order
    frame_step(9,  0, 32'h0, 1'b0);                    // empty FIFO
    frame_step(10, 4, {16'h9BDF, 16'h1357}, 1'b0);
    frame_step(11, 4, {16'h0C03, 16'hC001}, 1'b0);
    wait (frames_done == NSTEPS);
    check(fq.size() == 0, "R5", "fifo drained", 64'(fq.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule